// File: doc/BRIEF.md
# Calorimeter Tower-Window Electron/Photon Cluster Finder

This block takes one 3x3 window of calorimeter trigger towers at a time. The window is centred on a seed tower. Each tower carries an electromagnetic transverse energy and a hadronic transverse energy. From one window the block produces five results:

- an electron/photon candidate energy, taken from the best two-tower pair that contains the centre;
- a flag saying whether every tower in the window passes a hadronic-fraction cut;
- an isolation flag based on neighbour patterns;
- a tau-style sum of both layers over all nine towers;
- an output valid strobe.

The block is fully pipelined. It accepts a new window on every clock and returns each result a fixed number of cycles later. It is meant to be instantiated once per window position by a scanning stage upstream, which is not part of this block.

Towers are numbered 0 to 8, row by row, so tower 4 is the centre. Towers 1, 3, 5 and 7 are the edge neighbours and towers 0, 2, 6 and 8 are the corners. Tower k occupies bits [8k+7:8k] of each flat input bus. The isolation threshold is sampled together with the window it applies to.

Top module: `twc_cluster_top`

## Requirements
- R1: While reset is held and on the first cycles after it, `out_valid` is 0 and `out_cand`, `out_tau`, `out_ratio_ok` and `out_iso_ok` are 0. The reset is synchronous and active low.
- R2: A window presented with `in_valid` high at rising edge t produces its results, with `out_valid` high, just after rising edge t+2 (three register stages). Windows may arrive on consecutive cycles. A cycle with `in_valid` low yields a cycle with `out_valid` low.
- R3: `out_cand` is the largest of em[4]+em[1], em[4]+em[3], em[4]+em[5] and em[4]+em[7], saturated to 255.
- R4: The corner towers and all hadronic energies have no effect on `out_cand`.
- R5: `out_ratio_ok` is 1 exactly when all nine towers satisfy 8*had <= em.
- R6: A tower with em = 0 passes the ratio cut only if its had is also 0.
- R7: Each tower's energy for isolation is em+had. `out_iso_ok` is 1 when at least one of four groups has all five of its members below `iso_thr`. Each group is the row and the column through one corner: {0,1,2,3,6}, {0,1,2,5,8}, {0,3,6,7,8} and {2,5,6,7,8}.
- R8: The isolation comparison is strict. A tower whose em+had equals `iso_thr` is not below it, so `iso_thr` = 0 always gives `out_iso_ok` = 0.
- R9: `out_tau` is the exact sum of em and had over all nine towers. It is 13 bits wide, so the maximum of 18*255 = 4590 fits without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window strobe |
| in_em | input | 72 | Electromagnetic energies, tower k at [8k+7:8k] |
| in_had | input | 72 | Hadronic energies, same layout |
| iso_thr | input | 8 | Isolation threshold for this window |
| out_valid | output | 1 | Result strobe |
| out_cand | output | 8 | Saturated best pair energy |
| out_ratio_ok | output | 1 | All nine towers pass the hadronic-fraction cut |
| out_iso_ok | output | 1 | At least one isolation group is quiet |
| out_tau | output | 13 | Nine-tower sum of both layers |

## Verification
A corrupted pipeline register shows up at the ports exactly three edges after the window that went in. It appears as a result that belongs to a neighbouring window, or as a valid strobe that does not match its window. Streaming back-to-back windows with bubbles therefore exposes a wrong stage in the same cycle it lands.

Errors in the function itself show up on the affected output of that same window:
- a wrong pair index or a missing saturation clamp shows in `out_cand`;
- a wrong group mask or a `<=` comparison in place of `<` shows in `out_iso_ok`;
- a tau row that is truncated or skipped shows in `out_tau`.

// File: rtl/twc_pkg.sv
package twc_pkg;

    localparam int NT     = 9;
    localparam int SIDE   = 3;
    localparam int CENTRE = 4;
    localparam int N_EDGE = 4;
    localparam int N_GRP  = 4;

    // Edge neighbour j of the centre: 1, 3, 5, 7
    function automatic int edge_idx(input int j);
        return 2 * j + 1;
    endfunction

    // Corner j: 0, 2, 6, 8
    function automatic int corner_idx(input int j);
        return (j / 2) * 6 + (j % 2) * 2;
    endfunction

    // Group anchored at corner j: its row and column, centre excluded by geometry
    function automatic logic [NT-1:0] group_mask(input int j);
        logic [NT-1:0] m;
        int c;
        c = corner_idx(j);
        m = '0;
        for (int k = 0; k < NT; k++) begin
            if ((k / SIDE) == (c / SIDE) || (k % SIDE) == (c % SIDE))
                m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/twc_pair_sum.sv
module twc_pair_sum
    import twc_pkg::*;
#(
    parameter int ET_W = 8
) (
    input  logic [NT*ET_W-1:0]     em,
    output logic [N_EDGE*ET_W-1:0] pair_sat
);
    localparam int SUM_W = ET_W + 1;
    localparam logic [ET_W-1:0] ET_MAX = {ET_W{1'b1}};

    for (genvar j = 0; j < N_EDGE; j++) begin : g_edge
        logic [SUM_W-1:0] sum_d;
        always_comb begin
            sum_d = SUM_W'(em[CENTRE*ET_W +: ET_W]) + SUM_W'(em[edge_idx(j)*ET_W +: ET_W]);
            pair_sat[j*ET_W +: ET_W] = sum_d[SUM_W-1] ? ET_MAX : sum_d[ET_W-1:0];
        end
    end

endmodule

// File: rtl/twc_ratio_cut.sv
module twc_ratio_cut
    import twc_pkg::*;
#(
    parameter int ET_W  = 8,
    parameter int SHIFT = 3
) (
    input  logic [NT*ET_W-1:0] em,
    input  logic [NT*ET_W-1:0] had,
    output logic [NT-1:0]      ok
);
    localparam int CMP_W = ET_W + SHIFT;

    for (genvar k = 0; k < NT; k++) begin : g_tower
        logic [CMP_W-1:0] had_scaled_d;
        logic [CMP_W-1:0] em_ext_d;
        always_comb begin
            had_scaled_d = {had[k*ET_W +: ET_W], {SHIFT{1'b0}}};
            em_ext_d     = CMP_W'(em[k*ET_W +: ET_W]);
            ok[k]        = (had_scaled_d <= em_ext_d);
        end
    end

endmodule

// File: rtl/twc_iso_groups.sv
module twc_iso_groups
    import twc_pkg::*;
#(
    parameter int ET_W = 8
) (
    input  logic [NT*ET_W-1:0] em,
    input  logic [NT*ET_W-1:0] had,
    input  logic [ET_W-1:0]    thr,
    output logic [N_GRP-1:0]   grp_ok
);
    localparam int TOT_W = ET_W + 1;

    logic [NT-1:0] quiet_d;

    for (genvar k = 0; k < NT; k++) begin : g_tower
        logic [TOT_W-1:0] tot_d;
        always_comb begin
            tot_d      = TOT_W'(em[k*ET_W +: ET_W]) + TOT_W'(had[k*ET_W +: ET_W]);
            quiet_d[k] = (tot_d < TOT_W'(thr));
        end
    end

    for (genvar j = 0; j < N_GRP; j++) begin : g_grp
        localparam logic [NT-1:0] MASK = group_mask(j);
        always_comb grp_ok[j] = &(quiet_d | ~MASK);
    end

endmodule

// File: rtl/twc_cluster_top.sv
module twc_cluster_top
    import twc_pkg::*;
#(
    parameter int ET_W  = 8,
    parameter int TAU_W = $clog2(2 * NT * ((1 << ET_W) - 1) + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [NT*ET_W-1:0]  in_em,
    input  logic [NT*ET_W-1:0]  in_had,
    input  logic [ET_W-1:0]     iso_thr,
    output logic                out_valid,
    output logic [ET_W-1:0]     out_cand,
    output logic                out_ratio_ok,
    output logic                out_iso_ok,
    output logic [TAU_W-1:0]    out_tau
);

    typedef struct packed {
        logic               v;
        logic [NT*ET_W-1:0] em;
        logic [NT*ET_W-1:0] had;
        logic [ET_W-1:0]    thr;
    } st1_t;

    typedef struct packed {
        logic                     v;
        logic [N_EDGE*ET_W-1:0]   pair;
        logic [NT-1:0]            rok;
        logic [N_GRP-1:0]         gok;
        logic [SIDE*TAU_W-1:0]    row;
    } st2_t;

    typedef struct packed {
        logic             v;
        logic [ET_W-1:0]  cand;
        logic             rok;
        logic             iok;
        logic [TAU_W-1:0] tau;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [N_EDGE*ET_W-1:0] pair_w;
    logic [NT-1:0]          rok_w;
    logic [N_GRP-1:0]       gok_w;

    twc_pair_sum #(.ET_W(ET_W)) u_pair (
        .em       (pipe_q.s1.em),
        .pair_sat (pair_w)
    );

    twc_ratio_cut #(.ET_W(ET_W), .SHIFT(3)) u_ratio (
        .em  (pipe_q.s1.em),
        .had (pipe_q.s1.had),
        .ok  (rok_w)
    );

    twc_iso_groups #(.ET_W(ET_W)) u_iso (
        .em     (pipe_q.s1.em),
        .had    (pipe_q.s1.had),
        .thr    (pipe_q.s1.thr),
        .grp_ok (gok_w)
    );

    always_comb begin
        logic [TAU_W-1:0] acc;
        logic [TAU_W-1:0] tot;
        logic [ET_W-1:0]  best;

        pipe_d = pipe_q;

        // stage 1: capture window
        pipe_d.s1.v   = in_valid;
        pipe_d.s1.em  = in_em;
        pipe_d.s1.had = in_had;
        pipe_d.s1.thr = iso_thr;

        // stage 2: per-tower terms and row sums
        pipe_d.s2.v    = pipe_q.s1.v;
        pipe_d.s2.pair = pair_w;
        pipe_d.s2.rok  = rok_w;
        pipe_d.s2.gok  = gok_w;
        for (int r = 0; r < SIDE; r++) begin
            acc = '0;
            for (int c = 0; c < SIDE; c++) begin
                acc = acc + TAU_W'(pipe_q.s1.em[(r*SIDE+c)*ET_W +: ET_W])
                          + TAU_W'(pipe_q.s1.had[(r*SIDE+c)*ET_W +: ET_W]);
            end
            pipe_d.s2.row[r*TAU_W +: TAU_W] = acc;
        end

        // stage 3: reductions
        best = '0;
        for (int j = 0; j < N_EDGE; j++) begin
            if (pipe_q.s2.pair[j*ET_W +: ET_W] > best)
                best = pipe_q.s2.pair[j*ET_W +: ET_W];
        end
        tot = '0;
        for (int r = 0; r < SIDE; r++)
            tot = tot + pipe_q.s2.row[r*TAU_W +: TAU_W];
        pipe_d.s3.v    = pipe_q.s2.v;
        pipe_d.s3.cand = best;
        pipe_d.s3.rok  = &pipe_q.s2.rok;
        pipe_d.s3.iok  = |pipe_q.s2.gok;
        pipe_d.s3.tau  = tot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid    = pipe_q.s3.v;
    assign out_cand     = pipe_q.s3.cand;
    assign out_ratio_ok = pipe_q.s3.rok;
    assign out_iso_ok   = pipe_q.s3.iok;
    assign out_tau      = pipe_q.s3.tau;

    // ---------------- assertions ----------------
    logic [1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_cand_ge_centre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cand >= $past(pipe_q.s1.em[CENTRE*ET_W +: ET_W], 2)));

    assert_ratio_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.s2.v && !(&pipe_q.s2.rok)) |=> !out_ratio_ok);

    for (genvar k = 0; k < NT; k++) begin : g_chk
        assert_zero_em_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pipe_q.s1.v && pipe_q.s1.em[k*ET_W +: ET_W] == '0 && pipe_q.s1.had[k*ET_W +: ET_W] != '0)
            |=> !pipe_q.s2.rok[k]);
    end

    assert_zero_thr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.s1.v && pipe_q.s1.thr == '0) |=> (pipe_q.s2.gok == '0));

    assert_tau_ge_cand_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tau >= TAU_W'(out_cand)));

endmodule

// File: tb/twc_cluster_top_tb.sv
module twc_cluster_top_tb;

    localparam int NT    = 9;
    localparam int ET_W  = 8;
    localparam int TAU_W = 13;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                in_valid;
    logic [NT*ET_W-1:0]  in_em;
    logic [NT*ET_W-1:0]  in_had;
    logic [ET_W-1:0]     iso_thr;
    logic                out_valid;
    logic [ET_W-1:0]     out_cand;
    logic                out_ratio_ok;
    logic                out_iso_ok;
    logic [TAU_W-1:0]    out_tau;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int w_em  [NT];
    int w_had [NT];
    int w_thr;

    // expected history, index 1 = driven one cycle ago
    bit    h_v   [1:3];
    int    h_c   [1:3];
    bit    h_r   [1:3];
    bit    h_i   [1:3];
    int    h_t   [1:3];
    string h_tag [1:3];

    twc_cluster_top u_dut (
        .clk, .rst_n, .in_valid, .in_em, .in_had, .iso_thr,
        .out_valid, .out_cand, .out_ratio_ok, .out_iso_ok, .out_tau
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_group(input int c, input int k);
        return (k / 3 == c / 3) || (k % 3 == c % 3);
    endfunction

    // one cycle: check the window from three cycles ago, then drive a new one
    task automatic step(input bit v, input string tag);
        int cand, tau, s;
        bit rok, iok, g;
        @(negedge clk);
        if (!done) begin
            check({"R2 valid ", h_tag[3]}, int'(out_valid), int'(h_v[3]));
            if (h_v[3] && out_valid) begin
                check({"R3 cand ", h_tag[3]}, int'(out_cand), h_c[3]);
                check({"R5 ratio ", h_tag[3]}, int'(out_ratio_ok), int'(h_r[3]));
                check({"R7 iso ", h_tag[3]}, int'(out_iso_ok), int'(h_i[3]));
                check({"R9 tau ", h_tag[3]}, int'(out_tau), h_t[3]);
            end
        end
        for (int k = 3; k > 1; k--) begin
            h_v[k] = h_v[k-1]; h_c[k] = h_c[k-1]; h_r[k] = h_r[k-1];
            h_i[k] = h_i[k-1]; h_t[k] = h_t[k-1]; h_tag[k] = h_tag[k-1];
        end
        cand = 0;
        for (int j = 1; j < NT; j += 2) begin
            s = w_em[4] + w_em[j];
            if (s > 255) s = 255;
            if (s > cand) cand = s;
        end
        rok = 1; tau = 0;
        for (int k = 0; k < NT; k++) begin
            if (8 * w_had[k] > w_em[k]) rok = 0;
            tau += w_em[k] + w_had[k];
        end
        iok = 0;
        foreach (w_em[c]) begin
            if (c == 0 || c == 2 || c == 6 || c == 8) begin
                g = 1;
                for (int k = 0; k < NT; k++)
                    if (in_group(c, k) && (w_em[k] + w_had[k] >= w_thr)) g = 0;
                if (g) iok = 1;
            end
        end
        h_v[1] = v; h_c[1] = cand; h_r[1] = rok; h_i[1] = iok; h_t[1] = tau; h_tag[1] = tag;
        in_valid = v;
        iso_thr  = ET_W'(w_thr);
        for (int k = 0; k < NT; k++) begin
            in_em[k*ET_W +: ET_W]  = ET_W'(w_em[k]);
            in_had[k*ET_W +: ET_W] = ET_W'(w_had[k]);
        end
    endtask

    task automatic clear_window();
        for (int k = 0; k < NT; k++) begin w_em[k] = 0; w_had[k] = 0; end
        w_thr = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_valid = 1; in_em = '1; in_had = '1; iso_thr = '1;
        for (int k = 1; k <= 3; k++) begin
            h_v[k] = 0; h_c[k] = 0; h_r[k] = 0; h_i[k] = 0; h_t[k] = 0; h_tag[k] = "reset";
        end
        repeat (4) @(negedge clk);
        // R1: reset state while inputs are busy
        check("R1 valid", int'(out_valid), 0);
        check("R1 cand", int'(out_cand), 0);
        check("R1 tau", int'(out_tau), 0);
        check("R1 flags", int'({out_ratio_ok, out_iso_ok}), 0);
        in_valid = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1 valid after release", int'(out_valid), 0);

        // all zero: R6 zero/zero passes, R8 thr 0 fails isolation
        clear_window(); step(1, "zero window R6 R8");
        // R3 saturation
        clear_window(); w_em[4] = 200; w_em[5] = 100; w_thr = 255; step(1, "saturate R3");
        // R4 corners and hadronic ignored for candidate
        clear_window(); w_em[4] = 10; w_em[0] = 250; w_em[8] = 250; w_had[1] = 200; w_thr = 100;
        step(1, "corner R4");
        // R6 zero em with hadronic
        clear_window(); w_had[7] = 1; w_thr = 50; step(1, "zero em R6");
        // R5 boundary
        clear_window(); w_em[2] = 80; w_had[2] = 10; step(1, "ratio edge pass R5");
        clear_window(); w_em[2] = 80; w_had[2] = 11; step(1, "ratio edge fail R5");
        // R8 strict threshold
        for (int c = 0; c < 2; c++) begin
            clear_window();
            for (int k = 0; k < NT; k++) begin w_em[k] = 3; w_had[k] = 2 - c; end
            w_thr = 5;
            step(1, c == 0 ? "thr equal R8" : "thr below R7");
        end
        // R7 single quiet group (group of corner 8 only)
        clear_window();
        for (int k = 0; k < NT; k++) w_em[k] = (k == 2 || k == 5 || k == 6 || k == 7 || k == 8) ? 1 : 90;
        w_thr = 20; step(1, "one group R7");
        // R9 full scale
        for (int k = 0; k < NT; k++) begin w_em[k] = 255; w_had[k] = 255; end
        w_thr = 255; step(1, "full scale R9");
        // bubble
        step(0, "bubble R2");

        // sweep: centre against each edge neighbour
        for (int a = 0; a < 256; a += 5) begin
            for (int j = 0; j < 4; j++) begin
                clear_window();
                w_em[4] = a; w_em[2*j+1] = 255 - a + j * 7;
                if (w_em[2*j+1] > 255) w_em[2*j+1] = 255;
                w_had[4] = a >> 3; w_thr = a;
                step(1, "pair sweep R3");
            end
        end

        // random stream with bubbles
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < NT; k++) begin
                w_em[k]  = $urandom_range(0, (n % 3 == 0) ? 255 : 40);
                w_had[k] = (n % 4 == 0) ? $urandom_range(0, 255) : (w_em[k] >> $urandom_range(3, 5));
            end
            w_thr = $urandom_range(0, 120);
            step(($urandom_range(0, 4) != 0), "random R2 R3 R5 R7 R9");
        end
        clear_window();
        repeat (4) step(0, "drain R2");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule